// File: doc/BRIEF.md
# Handshaked Byte-Wide Register Port

This block lets an external host reach two 32-bit operand registers and a 32-bit result through one byte-wide data path. Each byte crosses under a four-phase handshake: the host lowers its strobe, the port raises its acknowledge, the port captures the byte and drops the acknowledge, and the host then returns the strobe high. A select line marks each byte as either an address byte or a data byte. The address byte picks an operand register and a byte lane. Data bytes that follow write into that lane. An address byte that selects the result side makes the port drive the matching result byte whenever its acknowledge is low.

A second request/done handshake starts the arithmetic engine. The engine itself lies outside this block. The port gives it the operands and a one-cycle start pulse. It raises its done output only after the engine reports completion, and it clears done once the host withdraws the request. Both host handshake inputs pass through multi-flop synchronisers, so the host may run from an unrelated, much slower clock.

Top module: `byte_reg_port`

## Requirements
- R1: After reset, port_ack, calc_done and eng_start are 0, both operand outputs are 0, the latched address is 0x00, and the port therefore drives result byte 0 (port_data_oe = 1).
- R2: Each low period of host_strobe_n produces exactly one rise and one fall of port_ack. A strobe held low after the acknowledge has dropped does not raise port_ack again.
- R3: An address byte (host_sel = 1) selects operand A when bit 2 is 0 and operand B when bit 2 is 1. Bits 1:0 select lane n, which covers bits 8n+7:8n. A data byte (host_sel = 0) writes only that lane of that operand. Operands change only in the cycle after a byte is committed.
- R4: The address stays latched across data bytes. Several data bytes sent after one address byte all write the same lane, and the last one wins.
- R5: While port_ack is low and the latched address has bit 2 = 0, port_data_oe is 1 and port_data_o carries the result byte of lane bits 1:0. When bit 2 = 1, port_data_oe is 0.
- R6: calc_done rises only in the cycle after eng_done was seen while a calculation was pending. It then stays high until calc_req goes low, and after that it falls.
- R7: One high period of calc_req gives exactly one single-cycle eng_start pulse.
- R8: port_data_oe is 0 whenever port_ack is 1.
- R9: Bits 7:3 of an address byte have no effect on which register or lane is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_strobe_n | input | 1 | Host transfer strobe, active low, asynchronous |
| host_sel | input | 1 | 1 = address byte, 0 = data byte |
| host_data_i | input | 8 | Byte driven by the host while port_ack is high |
| port_ack | output | 1 | Transfer acknowledge |
| port_data_o | output | 8 | Result byte presented to the host |
| port_data_oe | output | 1 | Output enable for port_data_o |
| calc_req | input | 1 | Host calculation request, asynchronous |
| calc_done | output | 1 | Calculation done handshake |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_result | input | 32 | Engine result word |
| op_a | output | 32 | Operand A register |
| op_b | output | 32 | Operand B register |

## Verification
The operands are loaded with distinct values in every lane. Any crossed lane or register decode therefore shows up at the operand outputs. Further tests write a single lane alone, send repeated data bytes after one address, and send an address byte with high garbage bits set. Together these separate lane isolation, the persistence of the latched address and the masking of bits 7:3. Result bytes are read back for several products, such as small values, 255x255 and a full 32-bit wrap. A long held strobe and a long held request show that only one access and only one start can occur per handshake. The engine completion is delayed, which shows that done waits for it.

// File: rtl/brp_pkg.sv
// Package: brp_pkg
// Shared width and state types for the byte-wide register port.
// Assumes an 8-bit host data path.
package brp_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_ACK  = 2'd1,
        XF_REL  = 2'd2
    } xfer_state_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } start_state_t;

    typedef struct packed {
        logic              is_addr;
        logic [BYTE_W-1:0] value;
    } byte_evt_t;
endpackage

// File: rtl/brp_sync.sv
// Module: brp_sync
// Multi-stage flop synchroniser for WIDTH independent asynchronous bits.
// Assumes each bit is a level that is held far longer than STAGES clocks.
module brp_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: first capture flop of the asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= d;
                end
            end else begin : g_next
                // Purpose: further settling flop of the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/brp_xfer.sv
// Module: brp_xfer
// Four-phase byte handshake. A synchronised low strobe raises ack for
// HOLD_CYC cycles. The byte is committed on the last of those cycles and
// ack then drops. The FSM re-arms only after the strobe returns high.
// Assumes the host holds sel and data stable while ack is high.
module brp_xfer
    import brp_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe_n_s,
    input  logic                sel_i,
    input  logic [BYTE_W-1:0]   data_i,
    output logic                ack_o,
    output logic                commit_o,
    output byte_evt_t           evt_o
);
    localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);

    xfer_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // Purpose: next-state logic of the transfer handshake.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE: if (!strobe_n_s)        state_d = XF_ACK;
            XF_ACK:  if (cnt_q == CNT_LAST)  state_d = XF_REL;
            XF_REL:  if (strobe_n_s)         state_d = XF_IDLE;
            default:                         state_d = XF_IDLE;
        endcase
    end

    // Purpose: state and hold counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XF_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == XF_ACK) cnt_q <= cnt_q + 1'b1;
            else                   cnt_q <= '0;
        end
    end

    assign ack_o         = (state_q == XF_ACK);
    assign commit_o      = (state_q == XF_ACK) && (cnt_q == CNT_LAST);
    assign evt_o.is_addr = sel_i;
    assign evt_o.value   = data_i;
endmodule

// File: rtl/brp_regs.sv
// Module: brp_regs
// Address latch, operand lane registers and result byte selector.
// Assumes committed events arrive one per cycle at most. Bits of an
// address byte above the register select are ignored.
module brp_regs
    import brp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  byte_evt_t         evt_i,
    input  logic [DATA_W-1:0] result_i,
    output logic [DATA_W-1:0] op_a_o,
    output logic [DATA_W-1:0] op_b_o,
    output logic [BYTE_W-1:0] rd_byte_o,
    output logic              rd_en_o
);
    localparam int LANES  = DATA_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);
    localparam int ADDR_W = LANE_W + 1;

    logic [ADDR_W-1:0] addr_q;
    logic [LANE_W-1:0] lane_q;
    logic              bsel_q;
    logic [BYTE_W-1:0] res_lane [LANES];

    assign lane_q = addr_q[LANE_W-1:0];
    assign bsel_q = addr_q[LANE_W];

    // Purpose: latch register select and lane from each address byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                         addr_q <= '0;
        else if (commit_i && evt_i.is_addr) addr_q <= evt_i.value[ADDR_W-1:0];
    end

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic wr_lane;
            assign wr_lane = commit_i && !evt_i.is_addr && (lane_q == LANE_W'(l));

            // Purpose: write one byte lane of the selected operand.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    op_a_o[l*BYTE_W +: BYTE_W] <= '0;
                    op_b_o[l*BYTE_W +: BYTE_W] <= '0;
                end else if (wr_lane) begin
                    if (bsel_q) op_b_o[l*BYTE_W +: BYTE_W] <= evt_i.value;
                    else        op_a_o[l*BYTE_W +: BYTE_W] <= evt_i.value;
                end
            end

            assign res_lane[l] = result_i[l*BYTE_W +: BYTE_W];
        end
    endgenerate

    assign rd_byte_o = res_lane[lane_q];
    assign rd_en_o   = !bsel_q;
endmodule

// File: rtl/brp_start.sv
// Module: brp_start
// Calculation request/done handshake. A synchronised request issues one
// start pulse. Done rises only after the engine reports completion and
// falls once the request is withdrawn.
// Assumes eng_done is a single-cycle pulse.
module brp_start
    import brp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic eng_done_i,
    output logic start_o,
    output logic done_o
);
    start_state_t state_q, state_d;

    // Purpose: next-state logic of the start handshake.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_s)      state_d = ST_BUSY;
            ST_BUSY: if (eng_done_i) state_d = ST_DONE;
            ST_DONE: if (!req_s)     state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign start_o = (state_q == ST_IDLE) && req_s;
    assign done_o  = (state_q == ST_DONE);
endmodule

// File: rtl/byte_reg_port.sv
// Module: byte_reg_port
// Top level of the byte-wide register port: input synchronisers, transfer
// handshake, register/lane store and the calculation start handshake.
// Assumes the host drives host_data_i only while port_ack is high.
module byte_reg_port #(
    parameter int DATA_W      = 32,
    parameter int HOLD_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_strobe_n,
    input  logic                       host_sel,
    input  logic [brp_pkg::BYTE_W-1:0] host_data_i,
    output logic                       port_ack,
    output logic [brp_pkg::BYTE_W-1:0] port_data_o,
    output logic                       port_data_oe,
    input  logic                       calc_req,
    output logic                       calc_done,
    output logic                       eng_start,
    input  logic                       eng_done,
    input  logic [DATA_W-1:0]          eng_result,
    output logic [DATA_W-1:0]          op_a,
    output logic [DATA_W-1:0]          op_b
);
    logic [1:0]         sync_q;
    logic               strobe_n_s;
    logic               req_s;
    logic               byte_commit;
    logic               rd_en;
    brp_pkg::byte_evt_t byte_evt;

    brp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({host_strobe_n, calc_req}),
        .q     (sync_q)
    );
    assign strobe_n_s = sync_q[1];
    assign req_s      = sync_q[0];

    brp_xfer #(.HOLD_CYC(HOLD_CYC)) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_n_s (strobe_n_s),
        .sel_i      (host_sel),
        .data_i     (host_data_i),
        .ack_o      (port_ack),
        .commit_o   (byte_commit),
        .evt_o      (byte_evt)
    );

    brp_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (byte_commit),
        .evt_i     (byte_evt),
        .result_i  (eng_result),
        .op_a_o    (op_a),
        .op_b_o    (op_b),
        .rd_byte_o (port_data_o),
        .rd_en_o   (rd_en)
    );

    brp_start u_start (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_s      (req_s),
        .eng_done_i (eng_done),
        .start_o    (eng_start),
        .done_o     (calc_done)
    );

    assign port_data_oe = rd_en && !port_ack;
endmodule

// File: rtl/brp_checker.sv
// Module: brp_checker
// Protocol checks for byte_reg_port, attached by bind.
module brp_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic              oe,
    input logic              start,
    input logic              done,
    input logic              eng_done,
    input logic              commit,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b
);
    assert_oe_off_during_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !oe);

    assert_single_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    assert_done_after_engine_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(eng_done));

    assert_op_a_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(op_a));

    assert_op_b_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(op_b));
endmodule

bind byte_reg_port brp_checker #(.DATA_W(DATA_W)) u_brp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (port_ack),
    .oe       (port_data_oe),
    .start    (eng_start),
    .done     (calc_done),
    .eng_done (eng_done),
    .commit   (byte_commit),
    .op_a     (op_a),
    .op_b     (op_b)
);

// File: tb/byte_reg_port_bench.sv
module byte_reg_port_bench;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_strobe_n = 1'b1;
    logic              host_sel = 1'b0;
    logic [7:0]        host_data_i = 8'h00;
    logic              port_ack;
    logic [7:0]        port_data_o;
    logic              port_data_oe;
    logic              calc_req = 1'b0;
    logic              calc_done;
    logic              eng_start;
    logic              eng_done = 1'b0;
    logic [DATA_W-1:0] eng_result = '0;
    logic [DATA_W-1:0] op_a, op_b;

    int checks = 0;
    int errors = 0;
    int ack_rises = 0;
    int start_pulses = 0;
    logic ack_prev = 1'b0;

    always #2 clk = ~clk;

    byte_reg_port u_byte_reg_port (.*);

    // monitors sample pre-edge values at each rising edge
    always @(posedge clk) begin
        if (port_ack && !ack_prev) ack_rises <= ack_rises + 1;
        ack_prev <= port_ack;
        if (eng_start) start_pulses <= start_pulses + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_byte(input logic sel, input logic [7:0] val, input int extra_low);
        int r0;
        r0 = ack_rises;
        host_sel = sel;
        host_strobe_n = 1'b0;
        @(negedge clk);
        while (port_ack !== 1'b1) @(negedge clk);
        check(port_data_oe == 1'b0, "R8 oe off while ack", {31'd0, port_data_oe}, 32'd0);
        host_data_i = val;
        while (port_ack !== 1'b0) @(negedge clk);
        host_data_i = 8'h00;
        repeat (extra_low) begin
            @(negedge clk);
            if (port_ack) check(1'b0, "R2 ack again under held strobe", 32'd1, 32'd0);
        end
        host_strobe_n = 1'b1;
        repeat (5) @(negedge clk);
        check(ack_rises == r0 + 1, "R2 one ack per strobe", ack_rises - r0, 32'd1);
    endtask

    task automatic write_word(input logic bsel, input logic [31:0] w);
        for (int l = 0; l < 4; l++) begin
            host_byte(1'b1, {5'd0, bsel, 2'(l)}, 0);
            host_byte(1'b0, w[l*8 +: 8], 0);
        end
    endtask

    task automatic t_reset();
        check(port_ack == 0 && calc_done == 0 && eng_start == 0, "R1 handshake outputs idle",
              {29'd0, port_ack, calc_done, eng_start}, 32'd0);
        check(op_a == 0, "R1 op_a zero", op_a, 32'd0);
        check(op_b == 0, "R1 op_b zero", op_b, 32'd0);
        check(port_data_oe == 1'b1, "R1 result byte 0 driven", {31'd0, port_data_oe}, 32'd1);
    endtask

    task automatic t_operands();
        write_word(1'b0, 32'h1234_5678);
        write_word(1'b1, 32'h9ABC_DEF0);
        check(op_a == 32'h1234_5678, "R3 operand A lanes", op_a, 32'h1234_5678);
        check(op_b == 32'h9ABC_DEF0, "R3 operand B lanes", op_b, 32'h9ABC_DEF0);
    endtask

    task automatic t_lane_isolation();
        host_byte(1'b1, 8'h06, 0);
        host_byte(1'b0, 8'h55, 0);
        check(op_b == 32'h9A55_DEF0, "R3 single lane of B", op_b, 32'h9A55_DEF0);
        check(op_a == 32'h1234_5678, "R3 A untouched", op_a, 32'h1234_5678);
    endtask

    task automatic t_latched_addr();
        host_byte(1'b1, 8'h01, 0);
        host_byte(1'b0, 8'hAA, 0);
        check(op_a == 32'h1234_AA78, "R4 first data byte", op_a, 32'h1234_AA78);
        host_byte(1'b0, 8'hBB, 0);
        check(op_a == 32'h1234_BB78, "R4 second data same lane", op_a, 32'h1234_BB78);
        check(op_b == 32'h9A55_DEF0, "R4 B untouched", op_b, 32'h9A55_DEF0);
    endtask

    task automatic t_upper_bits();
        host_byte(1'b1, 8'hF9, 0);
        host_byte(1'b0, 8'h3C, 0);
        check(op_a == 32'h1234_3C78, "R9 high address bits ignored", op_a, 32'h1234_3C78);
        check(op_b == 32'h9A55_DEF0, "R9 B untouched", op_b, 32'h9A55_DEF0);
    endtask

    task automatic t_long_strobe();
        host_byte(1'b1, 8'h00, 12);
        host_byte(1'b0, 8'h11, 12);
        check(op_a == 32'h1234_3C11, "R2 held strobe single write", op_a, 32'h1234_3C11);
    endtask

    task automatic t_calc(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] prod;
        int s0;
        write_word(1'b0, a);
        write_word(1'b1, b);
        prod = a * b;
        s0 = start_pulses;
        calc_req = 1'b1;
        repeat (10) @(negedge clk);
        check(start_pulses == s0 + 1, "R7 one start pulse", start_pulses - s0, 32'd1);
        repeat (10) @(negedge clk);
        check(calc_done == 1'b0, "R6 done waits for engine", {31'd0, calc_done}, 32'd0);
        eng_result = prod;
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        check(calc_done == 1'b1, "R6 done after engine", {31'd0, calc_done}, 32'd1);
        repeat (10) @(negedge clk);
        check(calc_done == 1'b1, "R6 done held with request", {31'd0, calc_done}, 32'd1);
        check(start_pulses == s0 + 1, "R7 no restart under held request", start_pulses - s0, 32'd1);
        calc_req = 1'b0;
        repeat (6) @(negedge clk);
        check(calc_done == 1'b0, "R6 done cleared", {31'd0, calc_done}, 32'd0);
        for (int l = 0; l < 4; l++) begin
            host_byte(1'b1, 8'(l), 0);
            check(port_data_oe == 1'b1, "R5 result driven", {31'd0, port_data_oe}, 32'd1);
            check(port_data_o == prod[l*8 +: 8], "R5 result byte", {24'd0, port_data_o}, {24'd0, prod[l*8 +: 8]});
        end
        host_byte(1'b1, 8'h04, 0);
        check(port_data_oe == 1'b0, "R5 B address not driven", {31'd0, port_data_oe}, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_operands();
        t_lane_isolation();
        t_latched_addr();
        t_upper_bits();
        t_long_strobe();
        t_calc(32'd21, 32'd54);
        t_calc(32'd255, 32'd255);
        t_calc(32'h1234_5678, 32'h9ABC_DEF0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule